// File: doc/BRIEF.md
# Single-Cell Charger Mode Sequencer

This block is the digital supervisor of a single-cell lithium charger. A set of external analog comparators reduces the supply, battery and temperature conditions to digital flags. The block samples these flags through a two-flop synchroniser and moves a state machine through power-down, sleep, power-on delay, standby, begin-charge, precharge, fast charge, constant-voltage, done, suspend and fault. From the current state it drives the enable for the power stage, a current-mode select for the regulator, reset and hold commands for the external safety timers, two open-drain status outputs and an open-drain active-low power-good.

The faults are ranked. Loss of supply ranks above loss of input power. Input power ranks above input overvoltage and the enable input. These rank above a latched timer fault, which ranks above an out-of-range pack or junction temperature, which ranks above a latched termination. In standby the timers are reset. A temperature suspend holds them, so charging resumes with the elapsed time kept. Each open-drain output is modelled as a "sink" bit: 1 pulls the pin low, and 0 leaves it high-impedance.

Top module: `charge_mode_ctrl`

## Requirements
- R1: While `uvlo_i` is high, every output is 0: the power stage is off, the timer commands are idle and all three open-drain pins are released. The other inputs have no effect.
- R2: With supply present but `in_det_i` low, the block is in sleep. `pwr_en_o`=0, `tmr_rst_o`=1, and both status sinks and `pgood_sink_o` are 0.
- R3: When input power appears after sleep or power-down, the block waits `POR_CYCLES` clocks. During the wait it holds both status sinks and `pgood_sink_o` at 0 and `tmr_rst_o` at 1. After the wait the outputs follow the other inputs.
- R4: With `chg_en_n_i` high, the block is in standby (`pwr_en_o`=0, `tmr_rst_o`=1, `pgood_sink_o`=1). When `chg_en_n_i` goes low, the block passes through a begin-charge cycle that asserts `tmr_rst_o`, then starts charging.
- R5: When `pack_ok_i` is low, charging is suspended. `pwr_en_o`=0, `tmr_hold_o`=1 and `tmr_rst_o`=0. When the pack returns to range, charging resumes without any `tmr_rst_o` pulse.
- R6: `ovp_i` high forces standby with `pgood_sink_o`=0. It is not latched: when `ovp_i` clears, the block resumes charging.
- R7: `tj_hot_i` high turns the power stage off with the timers held, in the same way as R5. When it clears, charging resumes.
- R8: The status pair {`stat_a_sink_o`,`stat_b_sink_o`} is 11 in precharge, 10 in fast charge and in constant voltage, 01 in done, and 00 in every off or fault state.
- R9: While charging, `cur_mode_o` is 01 (short recovery) if `bat_short_i` is high. Otherwise it is 10 (precharge) if `bat_low_i` is high and `bat_reg_i` is low, and 11 (fast) in all other cases. When the power stage is off, `cur_mode_o` is 00. `bat_reg_i` selects the constant-voltage state, which ranks above precharge.
- R10: `bat_scind_i` high forces the status pair to 00 while charging continues.
- R11: With `term_en_i` and `term_flag_i` both high, the block enters done: power off, `tmr_rst_o`=1, status 01. With `term_en_i` low, `term_flag_i` has no effect and the status follows R8 by `bat_low_i`.
- R12: A latched `tmr_fault_i` turns the power stage off with `tmr_hold_o`=1 and status 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uvlo_i | input | 1 | Supply below undervoltage threshold |
| in_det_i | input | 1 | Input power detected |
| ovp_i | input | 1 | Input overvoltage |
| bat_low_i | input | 1 | Battery below low-voltage (precharge) threshold |
| bat_short_i | input | 1 | Battery below short-circuit threshold |
| bat_scind_i | input | 1 | Short-circuit indication threshold crossed |
| bat_reg_i | input | 1 | Battery at regulation voltage |
| pack_ok_i | input | 1 | Pack temperature in range |
| tj_hot_i | input | 1 | Junction over-temperature (hysteresis external) |
| chg_en_n_i | input | 1 | Active-low charge enable |
| tmr_fault_i | input | 1 | Latched safety-timer fault |
| term_flag_i | input | 1 | Latched termination detected |
| term_en_i | input | 1 | Termination detection enabled |
| pwr_en_o | output | 1 | Power stage enable |
| cur_mode_o | output | 2 | 00 off, 01 short, 10 precharge, 11 fast |
| tmr_rst_o | output | 1 | Reset safety timers |
| tmr_hold_o | output | 1 | Hold safety timers |
| stat_a_sink_o | output | 1 | Status output A pulls low |
| stat_b_sink_o | output | 1 | Status output B pulls low |
| pgood_sink_o | output | 1 | Power-good pin pulls low (input good) |

## Verification
Random flag vectors are held long enough for the state machine to settle. The settled outputs are compared with a reference derived from the fault ranking. This separates the ranks of every pair of competing conditions, such as overvoltage against a timer fault or a hot pack against a latched termination. Directed sequences then cover the behaviour that depends on history and that the settled comparison cannot see. The power-on wait is sampled inside its window. Suspend and resume are watched cycle by cycle to confirm that no timer reset appears, while the standby-to-charge path must show exactly one. Power-down with all other flags toggled shows that those inputs have no effect.

// File: rtl/cmc_pkg.sv
// Shared types for the charger mode sequencer.
// Assumes the flag struct is sampled as one synchronised vector.
package cmc_pkg;

    typedef enum logic [3:0] {
        ST_PDOWN   = 4'd0,
        ST_SLEEP   = 4'd1,
        ST_POR     = 4'd2,
        ST_STANDBY = 4'd3,
        ST_BEGIN   = 4'd4,
        ST_PRE     = 4'd5,
        ST_FAST    = 4'd6,
        ST_CV      = 4'd7,
        ST_DONE    = 4'd8,
        ST_SUSPEND = 4'd9,
        ST_FAULT   = 4'd10
    } cmc_state_e;

    typedef struct packed {
        logic uvlo;
        logic in_det;
        logic ovp;
        logic bat_low;
        logic bat_short;
        logic bat_scind;
        logic bat_reg;
        logic pack_ok;
        logic tj_hot;
        logic en_n;
        logic tmr_fault;
        logic term_flag;
        logic term_en;
    } cmc_flags_t;

    localparam logic [1:0] MODE_OFF   = 2'b00;
    localparam logic [1:0] MODE_SHORT = 2'b01;
    localparam logic [1:0] MODE_PRE   = 2'b10;
    localparam logic [1:0] MODE_FAST  = 2'b11;

endpackage

// File: rtl/cmc_sync.sv
// Multi-stage flop synchroniser for a vector of independent level flags.
// Assumes each bit is a slow quasi-static level; no bus coherency is implied.
module cmc_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the flags through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cmc_seq.sv
// Mode state machine: ranks supply, input, enable, fault, temperature and
// termination conditions and walks through a counted power-on wait.
// Assumes synchronised flags; termination and timer-fault are latched outside.
module cmc_seq
    import cmc_pkg::*;
#(
    parameter int POR_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  cmc_flags_t fl,
    output cmc_state_e state
);
    localparam int CW = $clog2(POR_CYCLES + 1);
    localparam logic [CW-1:0] POR_LAST = CW'(POR_CYCLES - 1);

    cmc_state_e    nxt;
    logic [CW-1:0] por_cnt;

    // Charging phase picked from the battery flags.
    function automatic cmc_state_e phase(input cmc_flags_t f);
        if (f.bat_reg)      return ST_CV;
        else if (f.bat_low) return ST_PRE;
        else                return ST_FAST;
    endfunction

    // Next-state ranking of all conditions.
    always_comb begin
        nxt = state;
        if (fl.uvlo)                          nxt = ST_PDOWN;
        else if (!fl.in_det)                  nxt = ST_SLEEP;
        else begin
            case (state)
                ST_PDOWN, ST_SLEEP: nxt = ST_POR;
                ST_POR: nxt = (por_cnt == POR_LAST) ? ST_STANDBY : ST_POR;
                default: begin
                    if (fl.ovp || fl.en_n)               nxt = ST_STANDBY;
                    else if (state == ST_STANDBY)        nxt = ST_BEGIN;
                    else if (fl.tmr_fault)               nxt = ST_FAULT;
                    else if (state == ST_FAULT)          nxt = ST_BEGIN;
                    else if (!fl.pack_ok || fl.tj_hot)   nxt = ST_SUSPEND;
                    else if (fl.term_en && fl.term_flag) nxt = ST_DONE;
                    else if (state == ST_DONE)           nxt = ST_BEGIN;
                    else                                 nxt = phase(fl);
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_PDOWN;
        else        state <= nxt;
    end

    // Power-on wait counter, cleared outside the wait state.
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_POR) por_cnt <= '0;
        else                           por_cnt <= por_cnt + 1'b1;
    end

    assert_pdown_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fl.uvlo |=> state == ST_PDOWN);
    assert_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl.uvlo && !fl.in_det) |=> state == ST_SLEEP);
    assert_por_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STANDBY && $past(state) == ST_POR) |-> $past(por_cnt) == POR_LAST);
    assert_ovp_standby_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl.uvlo && fl.in_det && fl.ovp && state != ST_POR
         && state != ST_PDOWN && state != ST_SLEEP) |=> state == ST_STANDBY);
    assert_begin_from_standby_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BEGIN) |-> ($past(state) == ST_STANDBY || $past(state) == ST_DONE
                                 || $past(state) == ST_FAULT));
endmodule

// File: rtl/cmc_outdec.sv
// Output decode: power stage, current mode, timer commands and open-drain pins.
// Assumes a sink bit of 1 pulls the pin low; 0 leaves it released.
module cmc_outdec
    import cmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cmc_state_e state,
    input  cmc_flags_t fl,
    output logic       pwr_en,
    output logic [1:0] cur_mode,
    output logic       tmr_rst,
    output logic       tmr_hold,
    output logic       stat_a,
    output logic       stat_b,
    output logic       pgood
);
    logic charging;

    // Power stage and current mode from state and battery level.
    always_comb begin
        charging = (state == ST_PRE) || (state == ST_FAST) || (state == ST_CV);
        pwr_en   = charging;
        if (!charging)         cur_mode = MODE_OFF;
        else if (fl.bat_short) cur_mode = MODE_SHORT;
        else if (state == ST_PRE) cur_mode = MODE_PRE;
        else                   cur_mode = MODE_FAST;
    end

    // Timer commands: reset outside charging, hold while paused.
    always_comb begin
        tmr_rst  = (state == ST_SLEEP) || (state == ST_POR) || (state == ST_STANDBY)
                || (state == ST_BEGIN) || (state == ST_DONE);
        tmr_hold = (state == ST_SUSPEND) || (state == ST_FAULT);
    end

    // Status pair and power-good pin.
    always_comb begin
        stat_a = 1'b0;
        stat_b = 1'b0;
        case (state)
            ST_PRE:        begin stat_a = !fl.bat_scind; stat_b = !fl.bat_scind; end
            ST_FAST, ST_CV: stat_a = !fl.bat_scind;
            ST_DONE:       stat_b = 1'b1;
            default: ;
        endcase
        pgood = (state != ST_PDOWN) && (state != ST_SLEEP) && (state != ST_POR) && !fl.ovp;
    end

    assert_timer_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(tmr_rst && tmr_hold));
    assert_dual_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_a && stat_b) |-> (pwr_en && cur_mode != MODE_OFF));
    assert_off_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> cur_mode == MODE_OFF);
    assert_scind_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fl.bat_scind |-> !stat_a);
    assert_resume_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_SUSPEND && pwr_en) |-> !$past(tmr_rst));
endmodule

// File: rtl/charge_mode_ctrl.sv
// Top level of the charger mode sequencer: synchronises the comparator
// flags, runs the mode state machine and decodes the outputs.
// Assumes all inputs are asynchronous levels; outputs follow in three clocks.
module charge_mode_ctrl
    import cmc_pkg::*;
#(
    parameter int POR_CYCLES  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uvlo_i,
    input  logic       in_det_i,
    input  logic       ovp_i,
    input  logic       bat_low_i,
    input  logic       bat_short_i,
    input  logic       bat_scind_i,
    input  logic       bat_reg_i,
    input  logic       pack_ok_i,
    input  logic       tj_hot_i,
    input  logic       chg_en_n_i,
    input  logic       tmr_fault_i,
    input  logic       term_flag_i,
    input  logic       term_en_i,
    output logic       pwr_en_o,
    output logic [1:0] cur_mode_o,
    output logic       tmr_rst_o,
    output logic       tmr_hold_o,
    output logic       stat_a_sink_o,
    output logic       stat_b_sink_o,
    output logic       pgood_sink_o
);
    localparam int NFL = $bits(cmc_flags_t);

    cmc_flags_t     raw;
    logic [NFL-1:0] synced;
    cmc_flags_t     fl;
    cmc_state_e     state;

    // Gather the raw comparator flags into one vector.
    always_comb begin
        raw.uvlo      = uvlo_i;
        raw.in_det    = in_det_i;
        raw.ovp       = ovp_i;
        raw.bat_low   = bat_low_i;
        raw.bat_short = bat_short_i;
        raw.bat_scind = bat_scind_i;
        raw.bat_reg   = bat_reg_i;
        raw.pack_ok   = pack_ok_i;
        raw.tj_hot    = tj_hot_i;
        raw.en_n      = chg_en_n_i;
        raw.tmr_fault = tmr_fault_i;
        raw.term_flag = term_flag_i;
        raw.term_en   = term_en_i;
    end

    cmc_sync #(.WIDTH(NFL), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
    );

    assign fl = cmc_flags_t'(synced);

    cmc_seq #(.POR_CYCLES(POR_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .fl(fl), .state(state)
    );

    cmc_outdec u_dec (
        .clk(clk), .rst_n(rst_n), .state(state), .fl(fl),
        .pwr_en(pwr_en_o), .cur_mode(cur_mode_o),
        .tmr_rst(tmr_rst_o), .tmr_hold(tmr_hold_o),
        .stat_a(stat_a_sink_o), .stat_b(stat_b_sink_o), .pgood(pgood_sink_o)
    );
endmodule

// File: tb/tb_charge_mode_ctrl.sv
module tb_charge_mode_ctrl;
    localparam int HOLD = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uvlo, in_det, ovp, bat_low, bat_short, bat_scind, bat_reg;
    logic pack_ok, tj_hot, en_n, tmr_fault, term_flag, term_en;
    logic pwr_en, tmr_rst, tmr_hold, sa, sb, pg;
    logic [1:0] cur_mode;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    charge_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo), .in_det_i(in_det), .ovp_i(ovp),
        .bat_low_i(bat_low), .bat_short_i(bat_short), .bat_scind_i(bat_scind),
        .bat_reg_i(bat_reg), .pack_ok_i(pack_ok), .tj_hot_i(tj_hot),
        .chg_en_n_i(en_n), .tmr_fault_i(tmr_fault), .term_flag_i(term_flag),
        .term_en_i(term_en), .pwr_en_o(pwr_en), .cur_mode_o(cur_mode),
        .tmr_rst_o(tmr_rst), .tmr_hold_o(tmr_hold), .stat_a_sink_o(sa),
        .stat_b_sink_o(sb), .pgood_sink_o(pg)
    );

    // Packed output view: {pwr_en, mode[1:0], rst, hold, stat_a, stat_b, pg}.
    function automatic logic [7:0] outs();
        return {pwr_en, cur_mode, tmr_rst, tmr_hold, sa, sb, pg};
    endfunction

    // Settled expectation from the ranking in the requirements.
    function automatic logic [7:0] expect_settled();
        logic [1:0] m;
        logic [1:0] st;
        if (uvlo)                   return 8'b0_00_00_00_0;            // R1
        if (!in_det)                return 8'b0_00_10_00_0;            // R2
        if (ovp)                    return 8'b0_00_10_00_0;            // R6
        if (en_n)                   return 8'b0_00_10_00_1;            // R4
        if (tmr_fault)              return 8'b0_00_01_00_1;            // R12
        if (!pack_ok || tj_hot)     return 8'b0_00_01_00_1;            // R5 R7
        if (term_en && term_flag)   return 8'b0_00_10_01_1;            // R11
        if (bat_short)            m = 2'b01;                           // R9
        else if (bat_low && !bat_reg) m = 2'b10;
        else                      m = 2'b11;
        if (bat_scind)            st = 2'b00;                          // R10
        else if (bat_low && !bat_reg) st = 2'b11;                      // R8
        else                      st = 2'b10;
        return {1'b1, m, 2'b00, st, 1'b1};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_good();
        uvlo = 0; in_det = 1; ovp = 0; bat_low = 0; bat_short = 0; bat_scind = 0;
        bat_reg = 0; pack_ok = 1; tj_hot = 0; en_n = 0; tmr_fault = 0;
        term_flag = 0; term_en = 1;
    endtask

    function automatic bit rb(input int pct);
        return ($urandom % 100) < pct;
    endfunction

    // Watchdog: a hung run counts as one failure.
    initial begin
        cyc(200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        bit saw_rst;
        void'($urandom(32'h5eed_c0de));
        set_good();
        uvlo = 1;
        cyc(4);
        check("R1 reset state", outs(), 8'h00);
        rst_n = 1;

        // R1: power-down with other inputs toggling has no effect.
        for (int i = 0; i < 6; i++) begin
            in_det = rb(50); ovp = rb(50); en_n = rb(50); pack_ok = rb(50);
            bat_low = rb(50); term_flag = rb(50);
            cyc(5);
            check("R1 power-down ignores inputs", outs(), 8'h00);
        end

        // R2: sleep.
        set_good(); in_det = 0;
        cyc(HOLD);
        check("R2 sleep", outs(), expect_settled());

        // R3: inside the power-on wait.
        in_det = 1;
        cyc(6);
        check("R3 por window", outs(), 8'b0_00_10_00_0);
        cyc(HOLD);
        check("R3 after por fast charge", outs(), expect_settled());

        // R5: suspend holds, resume without reset.
        pack_ok = 0;
        cyc(HOLD);
        check("R5 suspend", outs(), 8'b0_00_01_00_1);
        pack_ok = 1;
        saw_rst = 0;
        for (int i = 0; i < 8; i++) begin
            cyc(1);
            if (tmr_rst) saw_rst = 1;
        end
        check("R5 resume no timer reset", {7'b0, saw_rst}, 8'h00);
        check("R5 resumed charging", outs(), expect_settled());

        // R4: standby then enable gives one begin-charge reset pulse.
        en_n = 1;
        cyc(HOLD);
        check("R4 standby", outs(), 8'b0_00_10_00_1);
        en_n = 0;
        cyc(2);
        saw_rst = 0;
        for (int i = 0; i < 6; i++) begin
            cyc(1);
            if (pwr_en && !saw_rst) saw_rst = 1'bx;
            if (tmr_rst) saw_rst = 1;
        end
        check("R4 begin resets then charges", {pwr_en, 6'b0, saw_rst}, 8'b1000_0001);

        // R6: overvoltage, then clears without latching.
        ovp = 1;
        cyc(HOLD);
        check("R6 ovp standby", outs(), 8'b0_00_10_00_0);
        ovp = 0;
        cyc(HOLD);
        check("R6 ovp not latched", outs(), expect_settled());

        // R7: junction over-temperature.
        tj_hot = 1;
        cyc(HOLD);
        check("R7 tj hot", outs(), 8'b0_00_01_00_1);
        tj_hot = 0;
        cyc(HOLD);
        check("R7 resume", outs(), expect_settled());

        // R11: termination disabled hides done; enabled shows done.
        term_flag = 1; term_en = 0; bat_low = 1;
        cyc(HOLD);
        check("R11 term disabled precharge", outs(), 8'b1_10_00_11_1);
        term_en = 1;
        cyc(HOLD);
        check("R11 done", outs(), 8'b0_00_10_01_1);

        // R12 timer fault; R9 short mode; R10 short indication.
        set_good(); tmr_fault = 1;
        cyc(HOLD);
        check("R12 timer fault", outs(), 8'b0_00_01_00_1);
        set_good(); bat_short = 1; bat_low = 1; bat_scind = 1;
        cyc(HOLD);
        check("R9 R10 short mode status off", outs(), 8'b1_01_00_00_1);
        set_good(); bat_reg = 1; bat_low = 1;
        cyc(HOLD);
        check("R8 cv shows fast status", outs(), 8'b1_11_00_10_1);

        // Random settled vectors across all requirements.
        for (int i = 0; i < 400; i++) begin
            uvlo = rb(8); in_det = rb(90); ovp = rb(10); en_n = rb(12);
            tmr_fault = rb(10); term_flag = rb(20); term_en = rb(70);
            pack_ok = rb(85); tj_hot = rb(10); bat_low = rb(40);
            bat_short = rb(15); bat_scind = rb(15); bat_reg = rb(20);
            cyc(HOLD);
            check("R1-R12 random settled", outs(), expect_settled());
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule